// File: doc/BRIEF.md
# Flow Match Routing Decision Unit

This block sits after the flow table lookup in a receive path. Each cycle it can take one parsed packet key and the flow entry that the lookup fetched for it. The key holds the source and destination IP addresses (IPv4 or IPv6), two 16-bit port fields and an 8-bit transport protocol. The block decides whether the entry really describes the packet's flow. It then chooses the exit ring number for the frame.

A usable match routes the frame in one of several ways. A drop flag forces the frame to the release ring. A 2-bit route selector picks the entry's own destination, the result of the peer/address lookup, or the result of a classifier rule. An offload flag replaces the entry's own destination with a programmed offload ring. A packet that spans several buffers can be excluded from that offload by configuration. Ring codes above the fixed range pass through a programmable remap table.

In first-fragment mode a match does not route the frame. It asks the caller to set the entry's lock flag, and a locked entry never again counts as a routing match. When no usable match exists, the frame follows the peer/address lookup result. Inputs arrive with a valid/ready handshake, and results leave one cycle later from a registered stage with its own valid/ready.

Top module: `flow_route_unit`

## Requirements
- R1: An entry whose `ent_valid` is 0 never produces a match, whatever its other fields hold.
- R2: With `key_is_v6`=1 a match needs equal 128-bit source and destination addresses, equal source and destination port fields and an equal protocol code between key and entry.
- R3: With `key_is_v6`=0 only address bits [31:0] are compared. A key or entry with any nonzero bit in address bits [127:32] does not match.
- R4: Only protocol codes 1, 6, 17, 50, 51 and 58 can match. For codes 1 and 58 both key port fields must be zero. For codes 50 and 51 the port fields carry the security index halves and are compared like ports.
- R5: When there is no usable match, `out_match` is 0 and the destination is `peer_dest` (after R9). A usable match is one with a hit, no first-fragment mode and a clear lock flag.
- R6: On a usable match with `ent_drop`=1 the destination is 5 (release ring), regardless of route selector and offload flag.
- R7: On a usable match without drop, `ent_route_sel` 0 or 2 selects `ent_dest`, 1 selects `peer_dest`, and 3 selects `rule_dest`.
- R8: In route selector 0 or 2, `ent_offload`=1 replaces `ent_dest` with `cfg_offload_ring`. This does not happen when `cfg_offload_multi_dis`=1 and `pkt_multi_buf`=1.
- R9: A chosen code of 11 or more becomes `cfg_remap_tbl[(code-11)*5 +: 5]`. Codes 0 to 10 pass unchanged.
- R10: When `cfg_frag_mode`=1 and `pkt_first_frag`=1, a hit raises `lock_wr` (set the entry's lock flag). In that case `out_match` is 0 and the destination is `peer_dest`. Without a hit `lock_wr` stays 0.
- R11: An entry with `ent_frag_lock`=1 that hits is treated as a failed search: `out_match`=0, the destination follows R5, and `lock_wr` is 0 unless R10 applies.
- R12: A transfer (`in_vld` and `in_rdy` at a clock edge) presents its result with `out_vld`=1 after that edge. `in_rdy` = !`out_vld` | `out_rdy`. While `out_rdy` is 0 the result holds unchanged. Every accepted input yields exactly one result, in order.
- R13: During reset `out_vld` and `lock_wr` are 0 and `in_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Key and entry are valid |
| in_rdy | output | 1 | Block can accept an input |
| key_is_v6 | input | 1 | Key addresses are IPv6 |
| key_src_ip | input | 128 | Key source address |
| key_dst_ip | input | 128 | Key destination address |
| key_src_port | input | 16 | Key source port / low security index |
| key_dst_port | input | 16 | Key destination port / high security index |
| key_proto | input | 8 | Key transport protocol code |
| ent_valid | input | 1 | Entry is valid |
| ent_src_ip | input | 128 | Entry source address |
| ent_dst_ip | input | 128 | Entry destination address |
| ent_src_port | input | 16 | Entry source port field |
| ent_dst_port | input | 16 | Entry destination port field |
| ent_proto | input | 8 | Entry protocol code |
| ent_dest | input | 5 | Entry exit ring code |
| ent_drop | input | 1 | Entry forces release ring |
| ent_offload | input | 1 | Entry requests offload ring |
| ent_route_sel | input | 2 | Destination source selector |
| ent_frag_lock | input | 1 | Entry's destination is locked out |
| pkt_first_frag | input | 1 | Packet is a first fragment |
| pkt_multi_buf | input | 1 | Packet spans several buffers |
| peer_dest | input | 5 | Peer/address lookup ring code |
| rule_dest | input | 5 | Classifier rule ring code |
| cfg_frag_mode | input | 1 | First-fragment mode enable |
| cfg_offload_multi_dis | input | 1 | No offload for multi-buffer packets |
| cfg_offload_ring | input | 5 | Programmed offload ring code |
| cfg_remap_tbl | input | 105 | Remap targets for codes 11..31, 5 bits each |
| out_vld | output | 1 | Result is valid |
| out_rdy | input | 1 | Consumer takes the result |
| out_match | output | 1 | Usable flow match |
| out_dest | output | 5 | Final exit ring code |
| lock_wr | output | 1 | Write 1 into the entry's lock flag (with out_vld) |

## Verification
The bench builds the block with its default parameters: 128-bit addresses with a 32-bit IPv4 field, 16-bit ports, an 8-bit protocol and 5-bit ring codes. With these values the remap threshold of 11 leaves 21 table slots. Both the entry's own code and the peer fallback code can land in the remap range. The release code 5 stays below the threshold and so escapes the remap. A fixed offload ring of 9 makes the offload override visible against entry codes. A stretch of throttled `out_rdy` exercises holding and ordering of results.

// File: rtl/flow_route_unit.sv
module flow_route_unit #(
  parameter int ADDR_W       = 128,
  parameter int V4_W         = 32,
  parameter int PORT_W       = 16,
  parameter int PROTO_W      = 8,
  parameter int DEST_W       = 5,
  parameter int REMAP_BASE   = 11,
  parameter int RELEASE_CODE = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  output logic                in_rdy,
  input  logic                key_is_v6,
  input  logic [ADDR_W-1:0]   key_src_ip,
  input  logic [ADDR_W-1:0]   key_dst_ip,
  input  logic [PORT_W-1:0]   key_src_port,
  input  logic [PORT_W-1:0]   key_dst_port,
  input  logic [PROTO_W-1:0]  key_proto,
  input  logic                ent_valid,
  input  logic [ADDR_W-1:0]   ent_src_ip,
  input  logic [ADDR_W-1:0]   ent_dst_ip,
  input  logic [PORT_W-1:0]   ent_src_port,
  input  logic [PORT_W-1:0]   ent_dst_port,
  input  logic [PROTO_W-1:0]  ent_proto,
  input  logic [DEST_W-1:0]   ent_dest,
  input  logic                ent_drop,
  input  logic                ent_offload,
  input  logic [1:0]          ent_route_sel,
  input  logic                ent_frag_lock,
  input  logic                pkt_first_frag,
  input  logic                pkt_multi_buf,
  input  logic [DEST_W-1:0]   peer_dest,
  input  logic [DEST_W-1:0]   rule_dest,
  input  logic                cfg_frag_mode,
  input  logic                cfg_offload_multi_dis,
  input  logic [DEST_W-1:0]   cfg_offload_ring,
  input  logic [((1<<DEST_W)-REMAP_BASE)*DEST_W-1:0] cfg_remap_tbl,
  output logic                out_vld,
  input  logic                out_rdy,
  output logic                out_match,
  output logic [DEST_W-1:0]   out_dest,
  output logic                lock_wr
);

  localparam int REMAP_N = (1 << DEST_W) - REMAP_BASE;
  localparam logic [PROTO_W-1:0] PR_ICMP4 = PROTO_W'(1);
  localparam logic [PROTO_W-1:0] PR_TCP   = PROTO_W'(6);
  localparam logic [PROTO_W-1:0] PR_UDP   = PROTO_W'(17);
  localparam logic [PROTO_W-1:0] PR_ESP   = PROTO_W'(50);
  localparam logic [PROTO_W-1:0] PR_AUTH  = PROTO_W'(51);
  localparam logic [PROTO_W-1:0] PR_ICMP6 = PROTO_W'(58);
  localparam logic [DEST_W-1:0]  D_REL    = DEST_W'(RELEASE_CODE);
  localparam logic [DEST_W-1:0]  D_BASE   = DEST_W'(REMAP_BASE);

  logic in_fire;
  assign in_rdy  = ~out_vld | out_rdy;
  assign in_fire = in_vld & in_rdy;

  logic upper_clear, addr_eq, proto_legal, is_icmp, icmp_ports_ok, hit;
  assign upper_clear = ~|key_src_ip[ADDR_W-1:V4_W] & ~|key_dst_ip[ADDR_W-1:V4_W] &
                       ~|ent_src_ip[ADDR_W-1:V4_W] & ~|ent_dst_ip[ADDR_W-1:V4_W];
  assign addr_eq = key_is_v6
                 ? (key_src_ip == ent_src_ip) && (key_dst_ip == ent_dst_ip)
                 : upper_clear && (key_src_ip[V4_W-1:0] == ent_src_ip[V4_W-1:0]) &&
                   (key_dst_ip[V4_W-1:0] == ent_dst_ip[V4_W-1:0]);

  always_comb begin
    unique case (key_proto)
      PR_ICMP4, PR_TCP, PR_UDP, PR_ESP, PR_AUTH, PR_ICMP6: proto_legal = 1'b1;
      default: proto_legal = 1'b0;
    endcase
  end
  assign is_icmp       = (key_proto == PR_ICMP4) || (key_proto == PR_ICMP6);
  assign icmp_ports_ok = ~is_icmp || (~|key_src_port && ~|key_dst_port);

  assign hit = ent_valid && proto_legal && icmp_ports_ok && addr_eq &&
               (key_proto == ent_proto) &&
               (key_src_port == ent_src_port) && (key_dst_port == ent_dst_port);

  logic frag_now, route_ok, offload_on;
  assign frag_now   = cfg_frag_mode & pkt_first_frag;
  assign route_ok   = hit & ~frag_now & ~ent_frag_lock;
  assign offload_on = ent_offload & ~(cfg_offload_multi_dis & pkt_multi_buf);

  logic [DEST_W-1:0] sel;
  always_comb begin
    if (!route_ok)     sel = peer_dest;
    else if (ent_drop) sel = D_REL;
    else begin
      case (ent_route_sel)
        2'd1:    sel = peer_dest;
        2'd3:    sel = rule_dest;
        default: sel = offload_on ? cfg_offload_ring : ent_dest;
      endcase
    end
  end

  logic [DEST_W-1:0] remap_arr [REMAP_N];
  for (genvar g = 0; g < REMAP_N; g++) begin : g_remap
    assign remap_arr[g] = cfg_remap_tbl[g*DEST_W +: DEST_W];
  end

  logic [DEST_W-1:0] rm_idx, final_dest;
  assign rm_idx     = sel - D_BASE;
  assign final_dest = (sel >= D_BASE) ? remap_arr[rm_idx] : sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_match <= 1'b0;
      out_dest  <= '0;
      lock_wr   <= 1'b0;
    end else if (in_rdy) begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_match <= route_ok;
        out_dest  <= final_dest;
        lock_wr   <= hit & frag_now;
      end else begin
        lock_wr   <= 1'b0;
      end
    end
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_rdy |=> out_vld && $stable(out_dest) && $stable(out_match) && $stable(lock_wr));

  p_invalid_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !ent_valid |=> !out_match && !lock_wr);

  p_drop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && ent_drop |=> !out_match || (out_dest == D_REL));

  p_locked_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && ent_frag_lock |=> !out_match);

  p_lock_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr |-> out_vld && !out_match);

  p_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !ent_valid && (peer_dest < D_BASE) |=> out_dest == $past(peer_dest));

  always_comb begin
    if (!rst_n) p_reset_r13: assert (in_rdy || out_rdy);
  end

endmodule

// File: tb/flow_route_unit_test.sv
`timescale 1ns/100ps
module flow_route_unit_test;

  localparam int AW = 128;
  localparam int DW = 5;
  localparam int RN = 21;
  localparam logic [DW-1:0] OFFLOAD_RING = 5'd9;

  typedef struct packed {
    logic          v6;
    logic [AW-1:0] ksip, kdip;
    logic [15:0]   ksp, kdp;
    logic [7:0]    kpr;
    logic          evalid;
    logic [AW-1:0] esip, edip;
    logic [15:0]   esp, edp;
    logic [7:0]    epr;
    logic [DW-1:0] edest;
    logic          edrop, eoff;
    logic [1:0]    esel;
    logic          elock, first, multi, fragcfg, offdis;
    logic [DW-1:0] peer, rule;
  } txn_t;

  typedef struct {
    logic          match;
    logic [DW-1:0] dest;
    logic          wr;
    string         tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  txn_t cur;
  logic in_vld = 0, out_rdy = 1;
  logic in_rdy, out_vld, out_match, lock_wr;
  logic [DW-1:0] out_dest;
  logic [RN*DW-1:0] remap_tbl;

  int checks = 0, failures = 0, sent = 0, recv = 0;
  bit stall_en = 0, finished = 0;
  exp_t sb[$];

  flow_route_unit uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
    .key_is_v6(cur.v6), .key_src_ip(cur.ksip), .key_dst_ip(cur.kdip),
    .key_src_port(cur.ksp), .key_dst_port(cur.kdp), .key_proto(cur.kpr),
    .ent_valid(cur.evalid), .ent_src_ip(cur.esip), .ent_dst_ip(cur.edip),
    .ent_src_port(cur.esp), .ent_dst_port(cur.edp), .ent_proto(cur.epr),
    .ent_dest(cur.edest), .ent_drop(cur.edrop), .ent_offload(cur.eoff),
    .ent_route_sel(cur.esel), .ent_frag_lock(cur.elock),
    .pkt_first_frag(cur.first), .pkt_multi_buf(cur.multi),
    .peer_dest(cur.peer), .rule_dest(cur.rule),
    .cfg_frag_mode(cur.fragcfg), .cfg_offload_multi_dis(cur.offdis),
    .cfg_offload_ring(OFFLOAD_RING), .cfg_remap_tbl(remap_tbl),
    .out_vld(out_vld), .out_rdy(out_rdy), .out_match(out_match),
    .out_dest(out_dest), .lock_wr(lock_wr)
  );

  function automatic logic [DW-1:0] tbl_val(int i);
    return DW'((i + (i / 11) * 3 + 1) % 11);
  endfunction

  initial for (int i = 0; i < RN; i++) remap_tbl[i*DW +: DW] = tbl_val(i);

  function automatic exp_t model(txn_t t, string tag);
    exp_t e;
    bit legal, icmp, addr_ok, hit, usable;
    logic [DW-1:0] c;
    legal = t.kpr inside {8'd1, 8'd6, 8'd17, 8'd50, 8'd51, 8'd58};
    icmp  = t.kpr inside {8'd1, 8'd58};
    if (t.v6) addr_ok = (t.ksip == t.esip) && (t.kdip == t.edip);
    else addr_ok = (t.ksip[AW-1:32] == 0) && (t.kdip[AW-1:32] == 0) &&
                   (t.esip[AW-1:32] == 0) && (t.edip[AW-1:32] == 0) &&
                   (t.ksip[31:0] == t.esip[31:0]) && (t.kdip[31:0] == t.edip[31:0]);
    hit = t.evalid && legal && !(icmp && (t.ksp != 0 || t.kdp != 0)) && addr_ok &&
          t.kpr == t.epr && t.ksp == t.esp && t.kdp == t.edp;
    usable = hit && !(t.fragcfg && t.first) && !t.elock;
    if (!usable) c = t.peer;
    else if (t.edrop) c = 5'd5;
    else if (t.esel == 2'd1) c = t.peer;
    else if (t.esel == 2'd3) c = t.rule;
    else if (t.eoff && !(t.offdis && t.multi)) c = OFFLOAD_RING;
    else c = t.edest;
    e.dest  = (c >= 11) ? tbl_val(int'(c) - 11) : c;
    e.match = usable;
    e.wr    = hit && t.fragcfg && t.first;
    e.tag   = tag;
    return e;
  endfunction

  function automatic txn_t base6();
    txn_t t;
    t = '0;
    t.v6 = 1;
    t.ksip = 128'h2001_0db8_0000_0001_0000_0000_0000_00a1;
    t.kdip = 128'hfe80_0000_1111_2222_3333_4444_5555_6666;
    t.ksp = 16'h1f90; t.kdp = 16'h0050; t.kpr = 8'd6;
    t.evalid = 1;
    t.esip = t.ksip; t.edip = t.kdip; t.esp = t.ksp; t.edp = t.kdp; t.epr = t.kpr;
    t.edest = 5'd3; t.peer = 5'd2; t.rule = 5'd10;
    return t;
  endfunction

  function automatic txn_t base4();
    txn_t t;
    t = base6();
    t.v6 = 0;
    t.ksip = 128'h0000_0000_0000_0000_0000_0000_c0a8_0101;
    t.kdip = 128'h0000_0000_0000_0000_0000_0000_0a00_0002;
    t.esip = t.ksip; t.edip = t.kdip; t.kpr = 8'd17; t.epr = 8'd17;
    return t;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send(txn_t t, string tag);
    cur = t;
    in_vld = 1;
    while (!in_rdy) begin @(negedge clk); #1; end
    sb.push_back(model(t, tag));
    sent++;
    @(negedge clk); #1;
    chk(out_vld === 1'b1, "R12", "out_vld after transfer", out_vld, 1);
    in_vld = 0;
  endtask

  int cyc = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_rdy <= !stall_en || (cyc % 3 == 1);
  end

  logic          held = 0;
  logic [DW-1:0] h_dest;
  logic          h_match, h_wr;
  always @(negedge clk) begin
    #1;
    if (rst_n && held) begin
      chk(out_vld === 1'b1 && out_dest === h_dest && out_match === h_match && lock_wr === h_wr,
          "R12", "held result changed", int'(out_dest), int'(h_dest));
    end
    held = rst_n && out_vld && !out_rdy;
    h_dest = out_dest; h_match = out_match; h_wr = lock_wr;
    if (rst_n && out_vld && out_rdy) begin
      exp_t e;
      recv++;
      if (sb.size() == 0) begin
        chk(0, "R12", "result with no accepted input", 1, 0);
      end else begin
        e = sb.pop_front();
        chk(out_match === e.match, e.tag, "out_match", out_match, e.match);
        chk(out_dest === e.dest, e.tag, "out_dest", int'(out_dest), int'(e.dest));
        chk(lock_wr === e.wr, e.tag, "lock_wr", lock_wr, e.wr);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    txn_t t;
    cur = base6();
    repeat (3) @(negedge clk);
    #1;
    chk(out_vld === 1'b0, "R13", "out_vld in reset", out_vld, 0);
    chk(lock_wr === 1'b0, "R13", "lock_wr in reset", lock_wr, 0);
    chk(in_rdy === 1'b1, "R13", "in_rdy in reset", in_rdy, 1);
    rst_n = 1;
    @(negedge clk); #1;

    send(base6(), "R2");
    t = base6(); t.ksp = 16'h1f91; send(t, "R2");
    t = base6(); t.kdip[64] = ~t.kdip[64]; send(t, "R2");
    t = base6(); t.epr = 8'd17; send(t, "R2");
    t = base6(); t.evalid = 0; send(t, "R1");
    t = base6(); t.evalid = 0; t.edrop = 1; send(t, "R1");

    t = base4(); t.edest = 5'd7; send(t, "R3");
    t = base4(); t.ksip[100] = 1; t.esip[100] = 1; send(t, "R3");
    t = base4(); t.edip[40] = 1; send(t, "R3");

    t = base6(); t.kpr = 8'd2; t.epr = 8'd2; send(t, "R4");
    t = base6(); t.kpr = 8'd58; t.epr = 8'd58; t.ksp = 0; t.kdp = 0; t.esp = 0; t.edp = 0; send(t, "R4");
    t = base4(); t.kpr = 8'd1; t.epr = 8'd1; send(t, "R4");
    t = base6(); t.kpr = 8'd50; t.epr = 8'd50; t.ksp = 16'hbeef; t.esp = 16'hbeef; t.kdp = 16'hdead; t.edp = 16'hdead; send(t, "R4");
    t = base6(); t.kpr = 8'd51; t.epr = 8'd51; t.kdp = 16'h1234; send(t, "R4");

    t = base6(); t.edrop = 1; t.esel = 2'd1; t.eoff = 1; send(t, "R6");
    t = base6(); t.edrop = 1; t.esel = 2'd3; send(t, "R6");

    t = base6(); t.esel = 2'd1; send(t, "R7");
    t = base6(); t.esel = 2'd3; send(t, "R7");
    t = base6(); t.esel = 2'd2; t.edest = 5'd8; send(t, "R7");

    t = base6(); t.eoff = 1; send(t, "R8");
    t = base6(); t.eoff = 1; t.esel = 2'd2; t.multi = 1; t.offdis = 1; send(t, "R8");
    t = base6(); t.eoff = 1; t.multi = 1; send(t, "R8");
    t = base6(); t.eoff = 1; t.offdis = 1; send(t, "R8");
    t = base6(); t.eoff = 1; t.esel = 2'd1; send(t, "R8");

    t = base6(); t.edest = 5'd20; send(t, "R9");
    t = base6(); t.edest = 5'd11; send(t, "R9");
    t = base6(); t.evalid = 0; t.peer = 5'd31; send(t, "R9");
    t = base6(); t.edest = 5'd10; send(t, "R9");

    t = base6(); t.evalid = 0; t.peer = 5'd4; send(t, "R5");
    t = base4(); t.ksp = 0; t.peer = 5'd0; send(t, "R5");

    t = base6(); t.fragcfg = 1; t.first = 1; send(t, "R10");
    t = base6(); t.fragcfg = 1; t.first = 1; t.ksp = 16'h0001; send(t, "R10");
    t = base6(); t.fragcfg = 1; t.first = 0; send(t, "R10");
    t = base6(); t.fragcfg = 0; t.first = 1; send(t, "R10");

    t = base6(); t.elock = 1; t.edrop = 1; send(t, "R11");
    t = base6(); t.elock = 1; t.peer = 5'd25; send(t, "R11");
    t = base6(); t.elock = 1; t.fragcfg = 1; t.first = 1; send(t, "R11");

    stall_en = 1;
    for (int i = 0; i < 24; i++) begin
      t = base6();
      t.edest = 5'(i + 3);
      t.esel = 2'(i % 4);
      t.edrop = (i % 7 == 3);
      t.eoff = (i % 5 == 1);
      t.evalid = (i % 6 != 5);
      send(t, "R12");
    end
    stall_en = 0;

    for (int i = 0; i < 50 && sb.size() != 0; i++) begin @(negedge clk); #1; end
    #1;
    chk(sb.size() == 0, "R12", "results still pending", sb.size(), 0);
    chk(recv == sent, "R12", "result count", recv, sent);
    finish_run();
  end

endmodule